// File: doc/BRIEF.md
# CSR Read-Modify-Write Access Unit

This block carries out the three register-access operations of a processor's control and status register space: swap, set-bits and clear-bits. It holds a small bank of control/status registers, decodes a 12-bit register address, checks the access against the current privilege level and against the read-only class of the address, and returns the value the register held before the access. When the access is not permitted, it returns an illegal-instruction indication and a cause code instead.

All three operations use one datapath. Each one produces a write value and a write mask, and the register receives `(old & ~mask) | (value & mask)`. The old value is taken from the register in the same cycle in which the new value is written back, so each access is an atomic read-modify-write. A second access in the next cycle sees the first one's result. When the source register field of a set or clear is x0, the mask is forced to zero and no write is attempted at all. Such an access is therefore a pure read, and a pure read is allowed on read-only registers.

The implemented space has six groups of `PER_GROUP` registers each. Every group combines a class (read/write when address bits [11:10] are 00, read-only when they are 11) with a privilege level (bits [9:8] equal to 0, 1 or 3). Inside a group, the low address byte runs from `LOW_BASE` upwards. Read/write registers reset to zero. A read-only register returns a fixed value: its own address zero-extended, with the top bit set.

Top module: `csr_acc_unit`

## Requirements
- R1: Every request accepted while `req_valid` is high is answered with `resp_valid` high in the following cycle. `resp_valid` is low in every cycle that follows a cycle without a request.
- R2: Operation code 0 (swap) returns the prior register value and writes `req_src` in full, whatever the value of `req_src_nz`.
- R3: Operation code 1 (set-bits) with `req_src_nz` high returns the prior value and writes `old | req_src`.
- R4: Operation code 2 (clear-bits) with `req_src_nz` high returns the prior value and writes `old & ~req_src`.
- R5: A set or clear with `req_src_nz` low writes nothing, whatever `req_src` holds, and returns the current value.
- R6: An address with bits [11:10] = 2'b11 is read-only. A read of it is legal and returns `{1'b1, zeros, address}`. Any write attempt to it is illegal: a swap, or a set or clear with `req_src_nz` high, even when `req_src` is zero.
- R7: An access whose address bits [9:8], taken as an unsigned number, exceed `req_priv` is illegal.
- R8: An address is implemented only when bits [11:10] are 00 or 11, bits [9:8] are not 2, and bits [7:0] lie in `LOW_BASE .. LOW_BASE+PER_GROUP-1` (0x40..0x41 by default). Any other address is illegal.
- R9: An illegal access gives `resp_illegal` = 1, `resp_cause` = `CAUSE_ILLEGAL` (2 by default) and `resp_rdata` = 0, and it changes no register. A legal access gives `resp_illegal` = 0 and `resp_cause` = 0.
- R10: Operation code 3 is reserved and always illegal.
- R11: Read and write are atomic. A request in the cycle right after a write to the same register returns the newly written value.
- R12: After reset, every read/write register reads zero, and `resp_valid` and `resp_illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_op | input | 2 | 0 swap, 1 set-bits, 2 clear-bits, 3 reserved |
| req_addr | input | 12 | Register address |
| req_src | input | XLEN | Source operand |
| req_src_nz | input | 1 | Source register field is not x0 |
| req_priv | input | 2 | Current privilege level (0, 1 or 3) |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_rdata | output | XLEN | Prior register value, or zero when illegal |
| resp_illegal | output | 1 | Access was refused |
| resp_cause | output | CAUSE_W | Exception cause, zero when legal |

## Verification
Two things can fall in the same cycle: the commit of one access's new value, and the sampling of the old value by the next access to the same register. The bench provokes this by holding `req_valid` high across consecutive cycles. It uses directed swap-then-swap and set-then-clear pairs on one address, and random runs whose addresses are drawn mostly from the twelve implemented registers. Each response is judged against a shadow model that applies the accesses strictly in order. A stale read, or a write lost at the boundary, shows up as a miscompare on the second access.

// File: rtl/csr_acc_pkg.sv
package csr_acc_pkg;

   typedef enum logic [1:0] {
      OP_SWAP  = 2'd0,
      OP_SET   = 2'd1,
      OP_CLEAR = 2'd2,
      OP_RSVD  = 2'd3
   } csr_op_e;

   localparam logic [1:0] CLS_RW = 2'b00;
   localparam logic [1:0] CLS_RO = 2'b11;
   localparam int         NUM_GROUPS = 6;

   // groups 0..2 are read/write, 3..5 read-only; priority levels 0, 1, 3
   function automatic logic [1:0] group_cls(input int g);
      return (g < 3) ? CLS_RW : CLS_RO;
   endfunction

   function automatic logic [1:0] group_priv(input int g);
      case (g % 3)
         0:       return 2'd0;
         1:       return 2'd1;
         default: return 2'd3;
      endcase
   endfunction

   function automatic logic [11:0] ent_addr(input int e, input int per, input int base);
      int g;
      int k;
      g = e / per;
      k = e % per;
      return {group_cls(g), group_priv(g), 8'(base + k)};
   endfunction

endpackage

// File: rtl/csr_acc_decode.sv
module csr_acc_decode
   import csr_acc_pkg::*;
#(
   parameter int PER_GROUP = 2,
   parameter int LOW_BASE  = 8'h40,
   parameter int NUM_ENT   = NUM_GROUPS * PER_GROUP
) (
   input  logic [11:0]        addr,
   input  logic [1:0]         priv,
   output logic [NUM_ENT-1:0] hit,
   output logic               any_hit,
   output logic               is_ro,
   output logic               priv_ok
);

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
      localparam logic [11:0] EA = ent_addr(e, PER_GROUP, LOW_BASE);
      assign hit[e] = (addr == EA);
   end

   assign any_hit = |hit;
   assign is_ro   = (addr[11:10] == CLS_RO);
   // R7: the privilege field of the address may not exceed the current level
   assign priv_ok = (addr[9:8] <= priv);

endmodule

// File: rtl/csr_acc_merge.sv
module csr_acc_merge
   import csr_acc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [1:0]      op,
   input  logic [XLEN-1:0] src,
   input  logic            src_nz,
   input  logic [XLEN-1:0] old_val,
   output logic            wr_req,
   output logic [XLEN-1:0] new_val
);

   logic [XLEN-1:0] mask;
   logic [XLEN-1:0] wval;

   always_comb begin
      mask   = '0;
      wval   = '0;
      wr_req = 1'b0;
      case (csr_op_e'(op))
         OP_SWAP: begin
            mask   = '1;
            wval   = src;
            wr_req = 1'b1;
         end
         OP_SET: begin
            mask   = src_nz ? src : '0;   // R5: x0 source gives a zero mask
            wval   = '1;
            wr_req = src_nz;
         end
         OP_CLEAR: begin
            mask   = src_nz ? src : '0;
            wval   = '0;
            wr_req = src_nz;
         end
         default: begin
            mask   = '0;
            wval   = '0;
            wr_req = 1'b0;
         end
      endcase
   end

   assign new_val = (old_val & ~mask) | (wval & mask);

endmodule

// File: rtl/csr_acc_bank.sv
module csr_acc_bank
   import csr_acc_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int PER_GROUP = 2,
   parameter int LOW_BASE  = 8'h40,
   parameter int NUM_ENT   = NUM_GROUPS * PER_GROUP
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_ENT-1:0]            we,
   input  logic [XLEN-1:0]               wdata,
   output logic [NUM_ENT-1:0][XLEN-1:0]  ent_q
);

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      localparam int          G  = e / PER_GROUP;
      localparam logic [11:0] EA = ent_addr(e, PER_GROUP, LOW_BASE);
      if (group_cls(G) == CLS_RO) begin : g_ro
         assign ent_q[e] = {1'b1, {(XLEN-13){1'b0}}, EA};
         // R6: a read-only entry is never offered a write
         a_r6_ro_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
            !we[e]);
      end else begin : g_rw
         logic [XLEN-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= '0;
            else if (we[e]) q <= wdata;
         end
         assign ent_q[e] = q;
      end
   end

endmodule

// File: rtl/csr_acc_unit.sv
module csr_acc_unit
   import csr_acc_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter int PER_GROUP     = 2,
   parameter int LOW_BASE      = 8'h40,
   parameter int CAUSE_W       = 4,
   parameter int CAUSE_ILLEGAL = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_op,
   input  logic [11:0]        req_addr,
   input  logic [XLEN-1:0]    req_src,
   input  logic               req_src_nz,
   input  logic [1:0]         req_priv,
   output logic               resp_valid,
   output logic [XLEN-1:0]    resp_rdata,
   output logic               resp_illegal,
   output logic [CAUSE_W-1:0] resp_cause
);

   localparam int NUM_ENT = NUM_GROUPS * PER_GROUP;
   localparam logic [CAUSE_W-1:0] CAUSE_V = CAUSE_W'(CAUSE_ILLEGAL);

   // elaboration-time parameter checks
   if (XLEN < 16) begin : g_bad_xlen
      initial $fatal(1, "csr_acc_unit: XLEN must be at least 16");
   end
   if (PER_GROUP < 1 || LOW_BASE < 0 || LOW_BASE + PER_GROUP > 256) begin : g_bad_span
      initial $fatal(1, "csr_acc_unit: register span leaves the low address byte");
   end
   if (CAUSE_ILLEGAL < 1 || CAUSE_ILLEGAL >= (1 << CAUSE_W)) begin : g_bad_cause
      initial $fatal(1, "csr_acc_unit: cause code does not fit CAUSE_W");
   end

   logic [NUM_ENT-1:0]           hit;
   logic                         any_hit;
   logic                         is_ro;
   logic                         priv_ok;
   logic [NUM_ENT-1:0][XLEN-1:0] ent_q;
   logic [XLEN-1:0]              old_val;
   logic [XLEN-1:0]              new_val;
   logic                         wr_req;
   logic                         illegal;
   logic                         commit;
   logic [NUM_ENT-1:0]           we;

   csr_acc_decode #(
      .PER_GROUP (PER_GROUP),
      .LOW_BASE  (LOW_BASE),
      .NUM_ENT   (NUM_ENT)
   ) u_dec (
      .addr    (req_addr),
      .priv    (req_priv),
      .hit     (hit),
      .any_hit (any_hit),
      .is_ro   (is_ro),
      .priv_ok (priv_ok)
   );

   always_comb begin
      old_val = '0;
      for (int e = 0; e < NUM_ENT; e++) begin
         if (hit[e]) old_val |= ent_q[e];
      end
   end

   csr_acc_merge #(.XLEN(XLEN)) u_mrg (
      .op      (req_op),
      .src     (req_src),
      .src_nz  (req_src_nz),
      .old_val (old_val),
      .wr_req  (wr_req),
      .new_val (new_val)
   );

   assign illegal = !any_hit || !priv_ok || (req_op == OP_RSVD) || (is_ro && wr_req);
   assign commit  = req_valid && !illegal && wr_req;
   assign we      = hit & {NUM_ENT{commit}};

   csr_acc_bank #(
      .XLEN      (XLEN),
      .PER_GROUP (PER_GROUP),
      .LOW_BASE  (LOW_BASE),
      .NUM_ENT   (NUM_ENT)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .wdata (new_val),
      .ent_q (ent_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid   <= 1'b0;
         resp_illegal <= 1'b0;
         resp_rdata   <= '0;
         resp_cause   <= '0;
      end else begin
         resp_valid   <= req_valid;
         resp_illegal <= req_valid && illegal;
         resp_rdata   <= (req_valid && !illegal) ? old_val : '0;
         resp_cause   <= (req_valid && illegal) ? CAUSE_V : '0;
      end
   end

   // R1: one-cycle response
   a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !resp_valid);

   // R5: an x0-source set or clear leaves the bank untouched
   a_r5_x0_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == OP_SET || req_op == OP_CLEAR) && !req_src_nz)
      |=> $stable(ent_q));

   // R6: a write attempt on a read-only address is refused
   a_r6_ro_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[11:10] == 2'b11 &&
       (req_op == OP_SWAP || (req_op != OP_RSVD && req_src_nz)))
      |=> resp_illegal);

   // R7: higher-privilege address refused
   a_r7_priv_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[9:8] > req_priv) |=> (resp_illegal && resp_rdata == '0));

   // R10: reserved operation refused
   a_r10_rsvd_op: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_RSVD) |=> resp_illegal);

   // R9: refused access changes no register; cause and data coherent
   a_r9_refused_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && illegal) |=> $stable(ent_q));
   a_r9_cause_coherent: assert property (@(posedge clk) disable iff (!rst_n)
      resp_illegal |-> (resp_cause == CAUSE_V && resp_rdata == '0));
   a_r9_legal_cause_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_illegal |-> (resp_cause == '0));

endmodule

// File: tb/sim_csr_acc_unit.sv
`timescale 1ns/1ps
module sim_csr_acc_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [1:0]  req_op;
   logic [11:0] req_addr;
   logic [31:0] req_src;
   logic        req_src_nz;
   logic [1:0]  req_priv;
   logic        resp_valid;
   logic [31:0] resp_rdata;
   logic        resp_illegal;
   logic [3:0]  resp_cause;

   always #10 clk = ~clk;

   csr_acc_unit u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_op       (req_op),
      .req_addr     (req_addr),
      .req_src      (req_src),
      .req_src_nz   (req_src_nz),
      .req_priv     (req_priv),
      .resp_valid   (resp_valid),
      .resp_rdata   (resp_rdata),
      .resp_illegal (resp_illegal),
      .resp_cause   (resp_cause)
   );

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   logic [31:0] shadow [0:4095];
   bit          pend = 0;
   bit          exp_ill;
   logic [31:0] exp_data;
   string       exp_tag;

   function automatic bit implemented(input logic [11:0] a);
      return (a[11:10] == 2'b00 || a[11:10] == 2'b11) && (a[9:8] != 2'd2) &&
             (a[7:0] == 8'h40 || a[7:0] == 8'h41);
   endfunction

   task automatic check_resp();
      n_vec++;
      if (pend) begin
         if (resp_valid !== 1'b1 || resp_illegal !== exp_ill || resp_rdata !== exp_data ||
             resp_cause !== (exp_ill ? 4'd2 : 4'd0)) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b ill=%0b cause=%0d data=%h, want valid=1 ill=%0b cause=%0d data=%h",
                     exp_tag, resp_valid, resp_illegal, resp_cause, resp_rdata,
                     exp_ill, exp_ill ? 2 : 0, exp_data);
         end
      end else if (resp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: got valid=%0b, want valid=0", resp_valid);
      end
   endtask

   task automatic step(input bit v, input logic [1:0] op, input logic [11:0] a,
                       input logic [31:0] s, input bit nz, input logic [1:0] pr,
                       input string tag);
      bit          wr;
      bit          ill;
      logic [31:0] old;
      @(negedge clk);
      check_resp();
      req_valid  = v;
      req_op     = op;
      req_addr   = a;
      req_src    = s;
      req_src_nz = nz;
      req_priv   = pr;
      pend       = v;
      if (v) begin
         wr  = (op == 2'd0) || (op != 2'd3 && nz);
         ill = !implemented(a) || (a[9:8] > pr) || (op == 2'd3) || (a[11:10] == 2'b11 && wr);
         old = (a[11:10] == 2'b11) ? (32'h8000_0000 | {20'd0, a}) : shadow[a];
         exp_ill  = ill;
         exp_data = ill ? 32'd0 : old;
         if (!ill && wr) begin
            case (op)
               2'd0:    shadow[a] = s;
               2'd1:    shadow[a] = old | s;
               default: shadow[a] = old & ~s;
            endcase
         end
         if (tag != "") exp_tag = tag;
         else if (op == 2'd3) exp_tag = "R10";
         else if (!implemented(a)) exp_tag = "R8";
         else if (a[9:8] > pr) exp_tag = "R7";
         else if (a[11:10] == 2'b11) exp_tag = "R6";
         else if (!wr) exp_tag = "R5";
         else if (op == 2'd0) exp_tag = "R2";
         else if (op == 2'd1) exp_tag = "R3";
         else exp_tag = "R4";
      end
   endtask

   initial begin
      #(20.0 * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) shadow[i] = 32'd0;
      void'($urandom(32'h5EED_C5A1));
      rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0;
      req_src = '0; req_src_nz = 1'b0; req_priv = 2'd3;
      repeat (3) @(negedge clk);
      // R12: reset state of the outputs
      n_vec++;
      if (resp_valid !== 1'b0 || resp_illegal !== 1'b0) begin
         n_bad++;
         $display("FAIL R12: got valid=%0b ill=%0b, want 0 0", resp_valid, resp_illegal);
      end
      rst_n = 1'b1;

      // R12: read/write registers read zero after reset
      step(1, 2'd1, 12'h040, 32'hFFFF_FFFF, 0, 2'd3, "R12");
      step(1, 2'd1, 12'h341, 32'h0, 0, 2'd3, "R12");
      // R2 then R11: back-to-back swaps on one register
      step(1, 2'd0, 12'h340, 32'hDEAD_BEEF, 0, 2'd3, "R2");
      step(1, 2'd0, 12'h340, 32'h1234_5678, 1, 2'd3, "R11");
      step(1, 2'd1, 12'h340, 32'h0000_FF00, 1, 2'd3, "R3");
      step(1, 2'd2, 12'h340, 32'h1200_00F0, 1, 2'd3, "R4");
      step(1, 2'd1, 12'h340, 32'h0, 0, 2'd3, "R11");
      // R5: x0 clear with all-ones operand, then confirm unchanged
      step(1, 2'd2, 12'h340, 32'hFFFF_FFFF, 0, 2'd3, "R5");
      step(1, 2'd1, 12'h340, 32'hFFFF_FFFF, 0, 2'd3, "R5");
      // R6: read-only reads legal, write attempts refused
      step(1, 2'd1, 12'hC40, 32'hFFFF_FFFF, 0, 2'd3, "R6");
      step(1, 2'd1, 12'hF41, 32'h0, 1, 2'd3, "R6");
      step(1, 2'd0, 12'hD40, 32'h0, 0, 2'd3, "R6");
      step(1, 2'd2, 12'hD40, 32'h0, 0, 2'd1, "R6");
      // R7: privilege
      step(1, 2'd0, 12'h140, 32'hAAAA_0001, 1, 2'd0, "R7");
      step(1, 2'd0, 12'h140, 32'hAAAA_0002, 1, 2'd1, "R7");
      step(1, 2'd1, 12'h341, 32'h0, 0, 2'd1, "R7");
      step(1, 2'd1, 12'h140, 32'h0, 0, 2'd0, "R7");
      // R8: unimplemented addresses
      step(1, 2'd1, 12'h342, 32'h0, 0, 2'd3, "R8");
      step(1, 2'd1, 12'h240, 32'h0, 0, 2'd3, "R8");
      step(1, 2'd0, 12'h840, 32'h1, 1, 2'd3, "R8");
      // R10 and R9: reserved op leaves register unchanged
      step(1, 2'd0, 12'h041, 32'h0000_0055, 1, 2'd0, "R2");
      step(1, 2'd3, 12'h041, 32'hFFFF_FFFF, 1, 2'd3, "R10");
      step(1, 2'd1, 12'h041, 32'h0, 0, 2'd0, "R9");
      // R1: gaps between requests
      step(0, 2'd0, 12'h040, 32'h0, 0, 2'd3, "R1");
      step(1, 2'd1, 12'h040, 32'h0, 0, 2'd3, "R1");
      step(0, 2'd0, 12'h040, 32'h0, 0, 2'd3, "R1");

      // constrained random, mostly back-to-back
      for (int n = 0; n < 1500; n++) begin
         logic [11:0] a;
         logic [1:0]  cls;
         logic [1:0]  pl;
         if ($urandom_range(0, 9) == 0) a = 12'($urandom);
         else begin
            cls = ($urandom_range(0, 3) == 0) ? 2'b11 : 2'b00;
            pl  = 2'($urandom_range(0, 3));
            if (pl == 2'd2 && $urandom_range(0, 1) == 0) pl = 2'd3;
            a = {cls, pl, 7'b0100000, 1'($urandom_range(0, 1))};
         end
         step($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), a, $urandom,
              $urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), "");
      end
      step(0, 2'd0, 12'h0, 32'h0, 0, 2'd3, "R1");
      @(negedge clk);
      check_resp();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule